// File: doc/BRIEF.md
# One-Shot Reference Selection Controller

This block decides which of two reference inputs drives a phase detector, and it reports that choice as a port index. In manual mode, an external select input sets the index on every clock. In automatic mode, the block watches a loss flag for the reference that is currently selected. When that flag rises, the block moves once to the other port.

The automatic switch happens only once. After it, the selection stays where it is, even if the new port also loses its reference. Automatic mode arms only when the automatic input is raised while the loss flag is low. To use the switch again, the system must drop the automatic input for at least one clock and then raise it again. All outputs are registered, and every decision is taken on the rising clock edge from the inputs sampled at that edge.

Top module: `refsel_oneshot`

## Requirements
- R1: While reset is asserted and after it is released, `ref_ack` is 0 (port 0) and `armed` is 0 until a clock edge samples other inputs.
- R2: At every clock edge with `auto_in` low, `ref_ack` takes the value of `man_sel` sampled at that edge, and `armed` is 0 after the edge.
- R3: At an edge where `auto_in` is high, the block was in manual mode, and `lor` is low, `armed` becomes 1 and `ref_ack` stays the same.
- R4: While `auto_in` is high and no switch is taken, `man_sel` has no effect and `ref_ack` holds the value it had when automatic mode was entered.
- R5: At an edge where `armed` is 1, `auto_in` is high and `lor` is high, `ref_ack` inverts (0 becomes 1, 1 becomes 0) and `armed` becomes 0.
- R6: After the one-shot switch, while `auto_in` stays high, `ref_ack` and `armed` do not change, whatever `lor` does.
- R7: If `auto_in` first rises while `lor` is high, `armed` stays 0 and `ref_ack` holds for as long as `auto_in` stays high, even after `lor` falls.
- R8: Re-arming takes at least one edge with `auto_in` low, followed by an edge with `auto_in` high and `lor` low.
- R9: Dropping `auto_in` at any point, including while armed, clears `armed` and returns to manual selection at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_in | input | 1 | 1 = automatic mode requested, 0 = manual mode |
| man_sel | input | 1 | Port chosen in manual mode |
| lor | input | 1 | Loss flag of the currently selected reference |
| ref_ack | output | 1 | Index of the port routed to the phase detector |
| armed | output | 1 | 1 while the one-shot switch is armed |

## Verification
The hardest case to reach is a spent or blocked automatic mode that lasts a long time while `lor` keeps toggling. A random walk that toggles `auto_in` often keeps passing through manual mode, so it rarely stays in that state for long. The stimulus therefore changes `auto_in` only rarely and toggles `lor` often. Directed sequences then cover four cases:
- arming while `lor` is already high;
- a second loss after the switch;
- dropping `auto_in` while armed;
- the re-arm sequence.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   typedef enum logic [1:0] {
      MODE_MANUAL = 2'd0,
      MODE_ARMED  = 2'd1,
      MODE_SPENT  = 2'd2
   } refsel_mode_e;
endpackage

// File: rtl/refsel_mode_fsm.sv
module refsel_mode_fsm
   import refsel_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic auto_in,
   input  logic lor,
   output logic flip,
   output logic armed
);
   refsel_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      flip   = 1'b0;
      if (!auto_in) begin
         mode_d = MODE_MANUAL;
      end else begin
         unique case (mode_q)
            MODE_MANUAL: mode_d = lor ? MODE_SPENT : MODE_ARMED;
            MODE_ARMED: begin
               if (lor) begin
                  flip   = 1'b1;
                  mode_d = MODE_SPENT;
               end
            end
            default: mode_d = MODE_SPENT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_MANUAL;
      else        mode_q <= mode_d;
   end

   assign armed = (mode_q == MODE_ARMED);

   // R9
   manual_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_in |=> !armed);
   // R3
   arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> ($past(auto_in) && !$past(lor)));
   // R6
   spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SPENT && auto_in) |=> (mode_q == MODE_SPENT));
   // R5
   switch_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> !armed);
endmodule

// File: rtl/refsel_sel_reg.sv
module refsel_sel_reg #(
   parameter int unsigned RESET_PORT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_in,
   input  logic man_sel,
   input  logic flip,
   output logic sel
);
   localparam logic RST_SEL = RESET_PORT[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel <= RST_SEL;
      else if (!auto_in) sel <= man_sel;
      else if (flip)     sel <= ~sel;
   end

   // R2
   manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_in |=> (sel == $past(man_sel)));
   // R4
   auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_in && !flip) |=> $stable(sel));
   // R5
   flip_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> (sel != $past(sel)));
endmodule

// File: rtl/refsel_oneshot.sv
module refsel_oneshot #(
   parameter int unsigned RESET_PORT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_in,
   input  logic man_sel,
   input  logic lor,
   output logic ref_ack,
   output logic armed
);
   generate
      if (RESET_PORT > 1) begin : g_bad_reset_port
         $error("RESET_PORT must be 0 or 1");
      end
   endgenerate

   logic flip;

   refsel_mode_fsm mode_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .auto_in (auto_in),
      .lor     (lor),
      .flip    (flip),
      .armed   (armed)
   );

   refsel_sel_reg #(.RESET_PORT(RESET_PORT)) sel_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .auto_in (auto_in),
      .man_sel (man_sel),
      .flip    (flip),
      .sel     (ref_ack)
   );

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (!armed && (ref_ack == RESET_PORT[0])));
endmodule

// File: tb/refsel_oneshot_tb_top.sv
module refsel_oneshot_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic auto_in = 1'b0, man_sel = 1'b0, lor = 1'b0;
   logic ref_ack, armed;
   int n_cmp = 0, n_bad = 0;
   int m_mode = 0;   // 0 manual, 1 armed, 2 spent
   logic m_sel = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   refsel_oneshot dut_i (
      .clk(clk), .rst_n(rst_n), .auto_in(auto_in), .man_sel(man_sel),
      .lor(lor), .ref_ack(ref_ack), .armed(armed)
   );

   function automatic string auto_tag(int md, logic a, logic l);
      if (!a)      return (md == 1) ? "R9" : "R2";
      if (md == 0) return l ? "R7" : "R3";
      if (md == 1) return l ? "R5" : "R4";
      return "R6";
   endfunction

   task automatic check(string tag, logic got_s, logic got_a, logic exp_s, logic exp_a);
      n_cmp++;
      if (got_s !== exp_s || got_a !== exp_a) begin
         n_bad++;
         $display("FAIL %s: ref_ack=%b armed=%b expected ref_ack=%b armed=%b",
                  tag, got_s, got_a, exp_s, exp_a);
      end
   endtask

   // drive at negedge, model the edge, compare just after the edge
   task automatic cyc(logic a, logic m, logic l, string tag = "");
      string t;
      @(negedge clk);
      auto_in = a; man_sel = m; lor = l;
      t = (tag == "") ? auto_tag(m_mode, a, l) : tag;
      if (!a) begin
         m_mode = 0; m_sel = m;
      end else if (m_mode == 0) begin
         m_mode = l ? 2 : 1;
      end else if (m_mode == 1) begin
         if (l) begin m_sel = ~m_sel; m_mode = 2; end
      end
      @(posedge clk); #1;
      check(t, ref_ack, armed, m_sel, (m_mode == 1));
   endtask

   initial begin
      #200000ns;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: ref_ack=%b armed=%b expected run to finish", ref_ack, armed);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      auto_in = 1'b1; man_sel = 1'b1; lor = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R1 in reset", ref_ack, armed, 1'b0, 1'b0);
      @(negedge clk); rst_n = 1'b1; auto_in = 1'b0; man_sel = 1'b0;
      #1 check("R1 after release", ref_ack, armed, 1'b0, 1'b0);

      // R2 manual follows man_sel
      cyc(0, 1, 0, "R2"); cyc(0, 0, 1, "R2"); cyc(0, 1, 1, "R2");
      // R3 arm, R4 man_sel ignored, R5 switch, R6 hold after second loss
      cyc(1, 0, 0, "R3"); cyc(1, 0, 0, "R4"); cyc(1, 1, 0, "R4");
      cyc(1, 0, 1, "R5"); cyc(1, 1, 0, "R6"); cyc(1, 1, 1, "R6"); cyc(1, 0, 0, "R6");
      // R8 re-arm only after manual pass
      cyc(0, 0, 0, "R8"); cyc(1, 1, 0, "R8"); cyc(1, 1, 1, "R5");
      // R7 blocked arming while loss high
      cyc(0, 1, 1, "R2"); cyc(1, 0, 1, "R7"); cyc(1, 0, 0, "R7"); cyc(1, 0, 1, "R7");
      // R9 drop while armed
      cyc(0, 0, 0, "R8"); cyc(1, 1, 0, "R3"); cyc(0, 1, 0, "R9"); cyc(0, 0, 0, "R2");

      // random: auto changes rarely, lor often
      for (int i = 0; i < 4000; i++) begin
         logic a, m, l;
         a = (($urandom % 16) == 0) ? ~auto_in : auto_in;
         m = (($urandom % 4) == 0) ? ~man_sel : man_sel;
         l = (($urandom % 3) == 0) ? ~lor : lor;
         cyc(a, m, l);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule